// File: doc/BRIEF.md
# Compact Four-Operation Registered ALU

This block is the arithmetic and logic core of a minimal soft processing element. It takes two operands and a two-bit operation select and registers one of four results on each enabled rising clock edge: sum, difference, bitwise AND or bitwise XOR. There is deliberately no OR; software builds it from the remaining operations, for example `(x ^ y) ^ (x & y)`.

The block registers four condition flags with the result:
- carry and signed overflow, from the adder;
- an operand-equality flag, formed from 2-bit group compares of the two operands;
- a zero flag, formed from 4-bit all-zero group tests of the selected result.

A second mode, chosen by `pass_en`, turns the unit into an add-or-pass element. It either adds the operands or forwards a third operand `c` unchanged. This lets a pipeline merge an adder and a result multiplexer into one stage.

The operands arrive as plain control-style inputs. There is no valid/ready handshake and no back-pressure. `ce` is the only flow control: while it is low, the stored result and flags are frozen and the inputs are ignored.

Top module: `alu4_reg`

## Requirements
- R1: With `pass_en`=0, `s1`=1, `s2`=1, the next result is a+b modulo 2^WIDTH. `flag_c` is the carry out of the sum. `flag_v` is 1 when the signed sum of a and b lies outside the signed WIDTH-bit range.
- R2: With `pass_en`=0, `s1`=1, `s2`=0, the next result is a-b modulo 2^WIDTH. `flag_c` is the carry out of a + ~b + 1, so 1 means no borrow (a >= b unsigned). `flag_v` is 1 when the signed difference lies outside the signed range.
- R3: With `pass_en`=0 and `s1`=0, the next result is a AND b when `s2`=1 and a XOR b when `s2`=0. In both cases `flag_c` and `flag_v` are 0.
- R4: With `pass_en`=1, `s1` is ignored. `s2`=1 gives a+b with carry and overflow as in R1. `s2`=0 gives `c` unchanged, with `flag_c` = `flag_v` = 0.
- R5: `flag_eq` is registered as 1 exactly when a equals b over all WIDTH bits, for every operation and mode.
- R6: `flag_z` is registered as 1 exactly when the result being stored is all zeros.
- R7: The result and flags change only at a rising clock edge. They show the operation applied to the inputs present at that edge, with one cycle of latency and no combinational path from inputs to outputs.
- R8: `rst` high at a rising edge clears the result and all four flags to 0, whatever the value of `ce`.
- R9: With `rst` low and `ce` low at a rising edge, the result and all flags keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for result and flags |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| c | input | WIDTH | Pass-through operand (pass mode only) |
| s1 | input | 1 | Select: 1 = arithmetic, 0 = logic (normal mode) |
| s2 | input | 1 | Select: add/AND when 1, subtract/XOR when 0; add/pass in pass mode |
| pass_en | input | 1 | 1 selects add-or-pass mode |
| result | output | WIDTH | Registered result |
| flag_c | output | 1 | Registered carry (no-borrow on subtract) |
| flag_v | output | 1 | Registered signed overflow |
| flag_z | output | 1 | Registered zero-result flag |
| flag_eq | output | 1 | Registered operand-equality flag |

## Verification
At a 4-bit width, every pair of a and b is applied under each of the eight combinations of `pass_en`, `s1` and `s2`, with `c` derived from the operands. This sweep covers all of the following:
- It separates add from subtract on the carry and overflow boundaries (for example 7+1, -8-1, 0-0).
- It separates AND from XOR.
- It exposes any group of the equality or zero reduction that ignores its bits.
- It confirms that `s1` has no effect in pass mode.

Directed steps then check the timing properties:
- outputs hold before the edge and while `ce` is low with changed inputs;
- reset wins over an asserted `ce`.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  // Operation code formed as {s1, s2}
  typedef enum logic [1:0] {
    OP_XOR = 2'b00,
    OP_AND = 2'b01,
    OP_SUB = 2'b10,
    OP_ADD = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic eq;
  } alu_flags_t;

  localparam int EQ_GROUP = 2;
  localparam int ZERO_GROUP = 4;

endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // Subtraction is a + ~b + 1 on the same carry chain
  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum   = full[WIDTH-1:0];
    carry = full[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu4_eqgrp.sv
module alu4_eqgrp #(
  parameter int WIDTH = 8,
  parameter int GROUP = 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             eq
);
  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PW   = NGRP * GROUP;

  logic [PW-1:0]   ap;
  logic [PW-1:0]   bp;
  logic [NGRP-1:0] grp_eq;

  assign ap = PW'(a);
  assign bp = PW'(b);

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    assign grp_eq[g] = (ap[g*GROUP +: GROUP] == bp[g*GROUP +: GROUP]);
  end

  assign eq = &grp_eq;
endmodule

// File: rtl/alu4_zgrp.sv
module alu4_zgrp #(
  parameter int WIDTH = 8,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] val,
  output logic             zero
);
  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PW   = NGRP * GROUP;

  logic [PW-1:0]   vp;
  logic [NGRP-1:0] grp_z;

  assign vp = PW'(val);

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    assign grp_z[g] = (vp[g*GROUP +: GROUP] == '0);
  end

  assign zero = &grp_z;
endmodule

// File: rtl/alu4_reg.sv
module alu4_reg
  import alu4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  input  logic             s1,
  input  logic             s2,
  input  logic             pass_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_z,
  output logic             flag_eq
);
  alu_op_e          op;
  logic             arith_sub;
  logic [WIDTH-1:0] sum;
  logic             carry;
  logic             ovf;
  logic             eq_n;
  logic             zero_n;
  logic [WIDTH-1:0] res_n;
  alu_flags_t       flg_n;
  alu_flags_t       flg_q;
  logic [WIDTH-1:0] res_q;

  assign op        = alu_op_e'({s1, s2});
  assign arith_sub = !pass_en && !s2;

  alu4_arith #(.WIDTH(WIDTH)) u_arith (
    .a(a), .b(b), .sub(arith_sub), .sum(sum), .carry(carry), .ovf(ovf)
  );

  alu4_eqgrp #(.WIDTH(WIDTH), .GROUP(EQ_GROUP)) u_eq (
    .a(a), .b(b), .eq(eq_n)
  );

  // Result select: pass mode first, then the normal nested select
  always_comb begin
    res_n   = sum;
    flg_n.c = 1'b0;
    flg_n.v = 1'b0;
    if (pass_en) begin
      if (s2) begin
        res_n   = sum;
        flg_n.c = carry;
        flg_n.v = ovf;
      end else begin
        res_n = c;
      end
    end else begin
      unique case (op)
        OP_ADD, OP_SUB: begin
          res_n   = sum;
          flg_n.c = carry;
          flg_n.v = ovf;
        end
        OP_AND:  res_n = a & b;
        default: res_n = a ^ b;
      endcase
    end
  end

  alu4_zgrp #(.WIDTH(WIDTH), .GROUP(ZERO_GROUP)) u_zero (
    .val(res_n), .zero(zero_n)
  );

  always_comb begin
    flg_n.z  = zero_n;
    flg_n.eq = eq_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (ce) begin
      res_q <= res_n;
      flg_q <= flg_n;
    end
  end

  assign result  = res_q;
  assign flag_c  = flg_q.c;
  assign flag_v  = flg_q.v;
  assign flag_z  = flg_q.z;
  assign flag_eq = flg_q.eq;
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] c,
  input logic             s1,
  input logic             s2,
  input logic             pass_en,
  input logic [WIDTH-1:0] result,
  input logic             flag_c,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_eq
);
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (ce && !pass_en && s1 && s2) |=> (result == WIDTH'($past(a) + $past(b)))); // R1

  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (ce && !pass_en && s1 && !s2) |=> (result == WIDTH'($past(a) - $past(b)))); // R2

  AST_LOGIC_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ce && !pass_en && !s1) |=> (!flag_c && !flag_v)); // R3

  AST_PASS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (ce && pass_en && !s2) |=> (result == $past(c) && !flag_c && !flag_v)); // R4

  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    ce |=> (flag_eq == ($past(a) == $past(b)))); // R5

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    ce |=> (flag_z == (result == '0))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result == '0 && !flag_c && !flag_v && !flag_z && !flag_eq)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)
             && $stable(flag_z) && $stable(flag_eq))); // R9
endmodule

bind alu4_reg alu4_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b), .c(c), .s1(s1), .s2(s2),
  .pass_en(pass_en), .result(result), .flag_c(flag_c), .flag_v(flag_v),
  .flag_z(flag_z), .flag_eq(flag_eq)
);

// File: tb/test_alu4_reg.sv
module test_alu4_reg;
  localparam int W = 4;
  localparam int M = (1 << W);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] c = '0;
  logic         s1 = 1'b0;
  logic         s2 = 1'b0;
  logic         pass_en = 1'b0;
  logic [W-1:0] result;
  logic         flag_c;
  logic         flag_v;
  logic         flag_z;
  logic         flag_eq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu4_reg #(.WIDTH(W)) i_alu4_reg (
    .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b), .c(c), .s1(s1), .s2(s2),
    .pass_en(pass_en), .result(result), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z), .flag_eq(flag_eq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= M / 2) ? v - M : v;
  endfunction

  // Drive inputs at the falling edge, then sample just after the next rising edge
  task automatic step(input int ia, input int ib, input int ic,
                      input bit is1, input bit is2, input bit ip, input bit ice);
    @(negedge clk);
    a = W'(ia); b = W'(ib); c = W'(ic);
    s1 = is1; s2 = is2; pass_en = ip; ce = ice;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag, input int er, input int ec,
                           input int ev, input int ez, input int eq);
    check({tag, " result"}, int'(result), er);
    check({tag, " C"}, int'(flag_c), ec);
    check({tag, " V"}, int'(flag_v), ev);
    check({tag, " Z (R6)"}, int'(flag_z), ez);
    check({tag, " EQ (R5)"}, int'(flag_eq), eq);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int er, ec, ev, sr, full;
    // R8: reset state
    repeat (2) @(posedge clk);
    #1;
    check_all("R8 reset", int'(result), 0, 0, 0, 0);
    check("R8 reset result", int'(result), 0);
    @(negedge clk);
    rst = 1'b0;

    // Exhaustive sweep: R1 R2 R3 R4
    for (int p = 0; p < 2; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int ia = 0; ia < M; ia++) begin
          for (int ib = 0; ib < M; ib++) begin
            int ic;
            string tag;
            ic = (ia * 5 + ib * 3 + 1) % M;
            step(ia, ib, ic, op[1], op[0], p[0], 1'b1);
            ec = 0; ev = 0;
            if (p == 1) begin
              tag = "R4";
              if (op[0]) begin
                full = ia + ib; er = full % M; ec = full / M;
                sr = sgn(ia) + sgn(ib);
                ev = (sr > M / 2 - 1 || sr < -M / 2) ? 1 : 0;
              end else begin
                er = ic;
              end
            end else if (op == 3) begin
              tag = "R1";
              full = ia + ib; er = full % M; ec = full / M;
              sr = sgn(ia) + sgn(ib);
              ev = (sr > M / 2 - 1 || sr < -M / 2) ? 1 : 0;
            end else if (op == 2) begin
              tag = "R2";
              full = ia + (M - 1 - ib) + 1; er = full % M; ec = full / M;
              sr = sgn(ia) - sgn(ib);
              ev = (sr > M / 2 - 1 || sr < -M / 2) ? 1 : 0;
            end else if (op == 1) begin
              tag = "R3 and";
              er = ia & ib;
            end else begin
              tag = "R3 xor";
              er = ia ^ ib;
            end
            check_all(tag, er, ec, ev, (er == 0) ? 1 : 0, (ia == ib) ? 1 : 0);
          end
        end
      end
    end

    // R7: load 5+2, then change inputs; output unchanged before the edge
    step(5, 2, 0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R7 loaded", int'(result), 7);
    @(negedge clk);
    a = 4'd1; b = 4'd1; s1 = 1'b0; s2 = 1'b0;
    #2;
    check("R7 no comb path", int'(result), 7);
    @(posedge clk);
    #1;
    check_all("R7 after edge", 0, 0, 0, 1, 1);

    // R9: ce low holds previous values with new inputs
    step(6, 3, 0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 load", int'(result), 9);
    step(0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_all("R9 hold", 9, 0, 1, 0, 0);
    step(15, 15, 4, 1'b1, 1'b0, 1'b1, 1'b0);
    check_all("R9 hold pass", 9, 0, 1, 0, 0);

    // R8: reset beats ce
    @(negedge clk);
    rst = 1'b1; ce = 1'b1; a = 4'd7; b = 4'd7; s1 = 1'b1; s2 = 1'b1; pass_en = 1'b0;
    @(posedge clk);
    #1;
    check_all("R8 reset with ce", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0; ce = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule